// File: doc/BRIEF.md
# Mode-Steered Asynchronous Preset and Load Register

This block is a register of parameterizable width, clocked on the rising edge of `clk`. It has two shared asynchronous control lines, `ctrl_a` and `ctrl_b`, and a static mode input that decides how those lines act on the stored value. Each stored bit is a storage cell with only two asynchronous inputs: a native clear and a native preset. Every other asynchronous effect is built from those two. A steering stage sends the controls, and where the mode needs it the `load_data` bits, to the native preset and clear. For some modes the register also runs in inverted form: the cell stores the complement of `d`, and the output complements it back.

The register supports these asynchronous behaviours:
- **Preset:** either native, or emulated with the clear plus inversion.
- **Preset with clear.**
- **Asynchronous load with clear:** the load copies `load_data` into the register by firing the preset for 1 bits and the clear for 0 bits.
- **Asynchronous load with preset:** this mode runs inverted.
- **Asynchronous load on its own.**

When no control line is asserted, `q` takes `d` on each rising clock edge. The controls are active high and act without a clock. They hold the output for as long as they stay asserted. The mode must only change while both control lines are low. There is no streaming data path, so every pin is a plain level.

Top module: `actl_reg`

## Requirements
- R1: Mode code 0 (native preset): while `ctrl_a` is high, every bit of `q` is 1 at once, with no clock edge needed. `ctrl_b` has no effect.
- R2: Mode code 1 (emulated preset, inverted storage): `q` behaves exactly like mode 0. `ctrl_a` forces every bit to 1, `ctrl_b` has no effect, and a clock edge with no control asserted puts `d` uninverted on `q`.
- R3: Mode code 2 (preset and clear): `ctrl_a` forces `q` to all ones and `ctrl_b` forces it to all zeros. When both are high, `q` is all zeros.
- R4: Mode code 3 (load and clear): `ctrl_a` copies `load_data` onto `q` asynchronously and follows changes of `load_data` while it is held. `ctrl_b` forces all zeros and wins over `ctrl_a`.
- R5: Mode code 4 (load and preset, inverted storage): `ctrl_b` forces `q` to all ones and wins over `ctrl_a`. `ctrl_a` on its own copies `load_data` onto `q`.
- R6: Mode code 5 (load only): `ctrl_a` copies `load_data` onto `q`. `ctrl_b` has no effect, so the register keeps capturing `d` on clock edges while only `ctrl_b` is high.
- R7: In mode codes 0, 1 and 2, `load_data` is ignored.
- R8: With both control lines low, `q` equals the value `d` had at the most recent rising edge of `clk`. This holds in every mode, including the inverted ones.
- R9: While a control forces `q`, clock edges and changes of `d` do not alter it. After the control is released, `q` keeps the forced value until the next rising edge.
- R10: Mode codes 6 and 7 are reserved. In them both control lines have no effect and the register only captures `d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the synchronous data path |
| mode | input | 3 | Static mode code (0 to 5 defined, 6 and 7 reserved) |
| ctrl_a | input | 1 | Asynchronous control line A, active high |
| ctrl_b | input | 1 | Asynchronous control line B, active high |
| d | input | W | Synchronous data input |
| load_data | input | W | Value copied by an asynchronous load |
| q | output | W | Register output |

## Verification
Results are due at two different times.
- **Asynchronous results** (forcing by a control line, and holding after release) are due in the same time step as the input change. The bench drives each input change just after a falling clock edge and samples `q` 1 ns later, before any rising edge.
- **Clocked results** (captures of `d`, and forced values still held across an edge) are due just after the next rising edge. The driver pushes the expected value into a queue at the falling edge. The monitor pops that value and compares it 1 ns after the following rising edge, so exactly one rising edge separates each stimulus from its check.

// File: rtl/actl_pkg.sv
package actl_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_PRESET_NATIVE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_PRESET_EMUL   = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PRESET_CLEAR  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_LOAD_CLEAR    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_LOAD_PRESET   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_LOAD_ONLY     = 3'd5;

  // Modes whose storage holds the complement of the visible value
  function automatic logic mode_inverted(input logic [MODE_W-1:0] m);
    return (m == MODE_PRESET_EMUL) || (m == MODE_LOAD_PRESET);
  endfunction

  // Modes in which load_data takes part
  function automatic logic mode_loads(input logic [MODE_W-1:0] m);
    return (m == MODE_LOAD_CLEAR) || (m == MODE_LOAD_PRESET) ||
           (m == MODE_LOAD_ONLY);
  endfunction

endpackage

// File: rtl/actl_steer.sv
module actl_steer
  import actl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              ctrl_a,
  input  logic              ctrl_b,
  input  logic [W-1:0]      load_data,
  output logic [W-1:0]      nat_pre,
  output logic [W-1:0]      nat_clr,
  output logic              invert
);

  logic [W-1:0] a_vec;
  logic [W-1:0] b_vec;

  assign a_vec = {W{ctrl_a}};
  assign b_vec = {W{ctrl_b}};

  always_comb begin
    nat_pre = '0;
    nat_clr = '0;
    invert  = mode_inverted(mode);
    case (mode)
      MODE_PRESET_NATIVE: begin
        nat_pre = a_vec;
      end
      MODE_PRESET_EMUL: begin
        // the clear of the complemented cell shows as a 1 at the output
        nat_clr = a_vec;
      end
      MODE_PRESET_CLEAR: begin
        nat_pre = a_vec;
        nat_clr = b_vec;
      end
      MODE_LOAD_CLEAR: begin
        nat_pre = a_vec & load_data;
        nat_clr = (a_vec & ~load_data) | b_vec;
      end
      MODE_LOAD_PRESET: begin
        // load value is complemented toward the cell
        nat_pre = a_vec & ~load_data;
        nat_clr = (a_vec & load_data) | b_vec;
      end
      MODE_LOAD_ONLY: begin
        nat_pre = a_vec & load_data;
        nat_clr = a_vec & ~load_data;
      end
      default: begin
        nat_pre = '0;
        nat_clr = '0;
      end
    endcase
  end

  // A lone load in a loading mode drives exactly one native input per bit
  always_comb begin
    if (mode_loads(mode) && ctrl_a && !ctrl_b) begin
      AST_LOAD_STEER_EXCL: assert ((nat_pre ^ nat_clr) == {W{1'b1}}); // R6
    end
  end

endmodule

// File: rtl/actl_cell.sv
module actl_cell (
  input  logic clk,
  input  logic pre,
  input  logic clr,
  input  logic din,
  output logic s
);

  // clear outranks preset when both are active
  always_ff @(posedge clk or posedge clr or posedge pre) begin
    if (clr) begin
      s <= 1'b0;
    end else if (pre) begin
      s <= 1'b1;
    end else begin
      s <= din;
    end
  end

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  AST_CLR_DOMINATES: assert property (@(posedge clk)
    clr |-> (s == 1'b0)); // R3

  AST_PRE_FORCES_ONE: assert property (@(posedge clk)
    (pre && !clr && primed && !$past(clr)) |-> (s == 1'b1)); // R1

  AST_CELL_CAPTURE: assert property (@(posedge clk) disable iff (pre || clr)
    (primed && !$past(pre) && !$past(clr)) |-> (s == $past(din))); // R8

endmodule

// File: rtl/actl_reg.sv
module actl_reg
  import actl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctrl_a,
  input  logic              ctrl_b,
  input  logic [W-1:0]      d,
  input  logic [W-1:0]      load_data,
  output logic [W-1:0]      q
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] nat_pre;
  logic [W-1:0] nat_clr;
  logic         invert;
  logic [W-1:0] cell_in;
  logic [W-1:0] cell_q;

  actl_steer #(.W(W)) u_steer (
    .mode      (mode),
    .ctrl_a    (ctrl_a),
    .ctrl_b    (ctrl_b),
    .load_data (load_data),
    .nat_pre   (nat_pre),
    .nat_clr   (nat_clr),
    .invert    (invert)
  );

  assign cell_in = invert ? ~d : d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    actl_cell u_cell (
      .clk (clk),
      .pre (nat_pre[i]),
      .clr (nat_clr[i]),
      .din (cell_in[i]),
      .s   (cell_q[i])
    );
  end

  assign q = invert ? ~cell_q : cell_q;

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  AST_NATIVE_PRESET: assert property (@(posedge clk)
    (mode == MODE_PRESET_NATIVE && ctrl_a) |-> (q == ALL_ONES)); // R1

  AST_EMUL_PRESET: assert property (@(posedge clk)
    (mode == MODE_PRESET_EMUL && ctrl_a) |-> (q == ALL_ONES)); // R2

  AST_PC_CLEAR_WINS: assert property (@(posedge clk)
    (mode == MODE_PRESET_CLEAR && ctrl_b) |-> (q == '0)); // R3

  AST_LC_LOAD: assert property (@(posedge clk)
    (mode == MODE_LOAD_CLEAR && ctrl_a && !ctrl_b && primed && !$past(ctrl_b))
      |-> (q == load_data)); // R4

  AST_LC_CLEAR: assert property (@(posedge clk)
    (mode == MODE_LOAD_CLEAR && ctrl_b) |-> (q == '0)); // R4

  AST_LP_PRESET: assert property (@(posedge clk)
    (mode == MODE_LOAD_PRESET && ctrl_b) |-> (q == ALL_ONES)); // R5

  AST_LOAD_ONLY: assert property (@(posedge clk)
    (mode == MODE_LOAD_ONLY && ctrl_a) |-> (q == load_data)); // R6

  AST_Q_FOLLOWS_D: assert property (@(posedge clk) disable iff (ctrl_a || ctrl_b)
    (primed && !$past(ctrl_a) && !$past(ctrl_b) && $past(mode) == mode)
      |-> (q == $past(d))); // R8

  AST_RSVD_IGNORES: assert property (@(posedge clk)
    (primed && mode > MODE_LOAD_ONLY && $past(mode) == mode)
      |-> (q == $past(d))); // R10

endmodule

// File: tb/actl_reg_tb.sv
`timescale 1ns/1ps
module actl_reg_tb;

  localparam int W = 4;

  typedef struct {
    bit           chk;
    logic [W-1:0] exp;
    string        req;
  } sb_item_t;

  logic         clk = 1'b0;
  logic [2:0]   mode;
  logic         ctrl_a;
  logic         ctrl_b;
  logic [W-1:0] d;
  logic [W-1:0] load_data;
  logic [W-1:0] q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;

  actl_reg #(.W(W)) u_dut (
    .clk       (clk),
    .mode      (mode),
    .ctrl_a    (ctrl_a),
    .ctrl_b    (ctrl_b),
    .d         (d),
    .load_data (load_data),
    .q         (q)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; queue the result due after the next rising edge
  task automatic step(input logic [2:0] m, input logic a, input logic b,
                      input logic [W-1:0] dv, input logic [W-1:0] ldv,
                      input logic [W-1:0] exp, input string req,
                      input bit imm, input logic [W-1:0] imm_exp);
    sb_item_t it;
    @(negedge clk);
    mode = m; ctrl_a = a; ctrl_b = b; d = dv; load_data = ldv;
    it.chk = 1'b1; it.exp = exp; it.req = req;
    sb.push_back(it);
    if (imm) begin
      #1;
      check(q, imm_exp, {req, " async"});
    end
  endtask

  // Monitor: one item popped 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        sb_item_t it;
        it = sb.pop_front();
        if (it.chk) check(q, it.exp, it.req);
      end
    end
  end

  initial begin
    mode = 3'd2; ctrl_a = 1'b0; ctrl_b = 1'b1; d = '0; load_data = '0;
    // reset state through a held clear
    step(3'd2, 0, 1, 4'h0, 4'h0, 4'h0, "R3 reset", 1, 4'h0);
    // preset and clear
    step(3'd2, 0, 0, 4'h5, 4'h0, 4'h5, "R8 capture", 0, 4'h0);
    step(3'd2, 1, 0, 4'h0, 4'h0, 4'hF, "R3 preset", 1, 4'hF);
    step(3'd2, 1, 1, 4'h0, 4'hA, 4'h0, "R3 both", 1, 4'h0);
    step(3'd2, 0, 1, 4'h3, 4'h0, 4'h0, "R3 clear", 1, 4'h0);
    step(3'd2, 0, 0, 4'hA, 4'h0, 4'hA, "R8 capture", 0, 4'h0);
    // native preset
    step(3'd0, 0, 0, 4'h3, 4'h0, 4'h3, "R8 mode0", 0, 4'h0);
    step(3'd0, 1, 0, 4'h0, 4'h0, 4'hF, "R1 preset", 1, 4'hF);
    step(3'd0, 1, 0, 4'h0, 4'h5, 4'hF, "R7 load_data ignored", 1, 4'hF);
    step(3'd0, 1, 1, 4'h9, 4'h0, 4'hF, "R1 ctrl_b no effect", 1, 4'hF);
    step(3'd0, 0, 0, 4'h6, 4'h0, 4'h6, "R9 hold then capture", 1, 4'hF);
    // emulated preset
    step(3'd1, 0, 0, 4'h9, 4'h0, 4'h9, "R2 inverted capture", 0, 4'h0);
    step(3'd1, 1, 0, 4'h0, 4'h0, 4'hF, "R2 preset", 1, 4'hF);
    step(3'd1, 1, 1, 4'h0, 4'hA, 4'hF, "R7 load_data ignored", 1, 4'hF);
    step(3'd1, 0, 1, 4'hC, 4'h0, 4'hC, "R2 ctrl_b no effect", 1, 4'hF);
    step(3'd1, 0, 0, 4'h1, 4'h0, 4'h1, "R2 capture", 0, 4'h0);
    // load and clear
    step(3'd3, 0, 0, 4'hF, 4'h0, 4'hF, "R8 mode3", 0, 4'h0);
    step(3'd3, 1, 0, 4'h0, 4'h5, 4'h5, "R4 load", 1, 4'h5);
    step(3'd3, 1, 0, 4'h0, 4'hA, 4'hA, "R4 follow", 1, 4'hA);
    step(3'd3, 1, 1, 4'h0, 4'hA, 4'h0, "R4 clear wins", 1, 4'h0);
    step(3'd3, 0, 1, 4'h0, 4'h0, 4'h0, "R4 clear", 1, 4'h0);
    step(3'd3, 0, 0, 4'h7, 4'h0, 4'h7, "R8 capture", 0, 4'h0);
    // load and preset
    step(3'd4, 0, 0, 4'h2, 4'h0, 4'h2, "R8 inverted capture", 0, 4'h0);
    step(3'd4, 0, 1, 4'h0, 4'h0, 4'hF, "R5 preset", 1, 4'hF);
    step(3'd4, 1, 0, 4'h0, 4'h6, 4'h6, "R5 load", 1, 4'h6);
    step(3'd4, 1, 0, 4'h0, 4'h9, 4'h9, "R5 follow", 1, 4'h9);
    step(3'd4, 1, 1, 4'h0, 4'h0, 4'hF, "R5 preset wins", 1, 4'hF);
    step(3'd4, 0, 0, 4'h4, 4'h0, 4'h4, "R9 hold then capture", 1, 4'hF);
    // load only
    step(3'd5, 0, 0, 4'h8, 4'h0, 4'h8, "R8 mode5", 0, 4'h0);
    step(3'd5, 1, 0, 4'h0, 4'h3, 4'h3, "R6 load", 1, 4'h3);
    step(3'd5, 0, 1, 4'h1, 4'h0, 4'h1, "R6 ctrl_b no effect", 1, 4'h3);
    step(3'd5, 0, 0, 4'hE, 4'h0, 4'hE, "R6 capture", 0, 4'h0);
    // reserved codes
    step(3'd6, 0, 0, 4'hD, 4'h0, 4'hD, "R10 capture", 0, 4'h0);
    step(3'd6, 1, 1, 4'h5, 4'h0, 4'h5, "R10 controls ignored", 1, 4'hD);
    step(3'd7, 1, 0, 4'hB, 4'hF, 4'hB, "R10 code 7", 1, 4'h5);
    step(3'd7, 0, 0, 4'h0, 4'h0, 4'h0, "R10 capture", 0, 4'h0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: q=%h expected completion", q);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule